// File: doc/BRIEF.md
# Double-Buffered Frame Fetch Sequencer

This block decides, once per frame, what the display fetch engine should read. When a frame starts it picks the current buffer's start address and skips the colour lookup table header that sits in front of the pixels. It then works out the total byte count and the bytes per line from the panel size and the colour depth. Before any fetch is released, it checks that this amount of data fits between the buffer's start and end addresses.

A frame that does not fit raises a sync error and asks the register block to drop the controller enable. A frame that fits produces a fetch command, a buffer-done pulse for the buffer just used and, if enabled, an interrupt. In dual-buffer mode the next frame then uses the other buffer. A subpanel setting can move the first displayed line or cut the number of displayed lines.

When the enable rises, the block checks that every buffer address in use lies inside an allowed address window. If they do, it issues a one-time request to load the lookup table. All status outputs are single-cycle pulses meant for a register block. The memory bus itself lies outside this block.

Top module: `frame_fetch_seq`

## Requirements
- R1: After reset every pulse output (fetch_go, buf_done, dma_irq, sync_err, bounds_fault, disable_req, pal_done, off_done) is low and buf_idx is 0.
- R2: One cycle after enable_i rises, if the bounds check passes and mode is not 2, pal_done pulses with pal_addr equal to top0. In mode 2 no palette request is made.
- R3: On the enable rise, the checked addresses are top0 and bot0, plus top1 and bot1 when dual is 1. If any of them lies outside win_lo..win_hi (inclusive), then one cycle later bounds_fault and disable_req pulse, dma_irq pulses if irq_mask[1] is 1, and frame starts are then ignored until enable is raised again.
- R4: The header offset is 0 in mode 2. Otherwise it is 512 bytes for depth codes 3 to 7 and 32 bytes for depth codes 1 and 2. fetch_base equals the current buffer's top address plus this offset.
- R5: Depth codes 1, 2, 3 and 4..7 mean 2, 4, 8 and 16 bits per pixel. With w = width_m1+1 and h = height_m1+1, fetch_bytes is floor(w*h*bpp/8) and line_bytes is floor(w*bpp/8).
- R6: If the offset plus fetch_bytes exceeds bottom minus top plus 2 for the current buffer, then one cycle after frame_start sync_err and disable_req pulse and fetch_go stays low. Later frame starts are ignored until enable is raised again. A frame needing exactly bottom-top+2 bytes is accepted.
- R7: For an accepted frame, fetch_go pulses one cycle after frame_start. buf_done pulses the bit of the buffer used (bit 0 for buffer 0, bit 1 for buffer 1), and dma_irq pulses when irq_mask[0] is 1.
- R8: With dual set, buf_idx toggles after each accepted frame and buffer 1 frames use top1/bot1. With dual clear, buf_idx stays 0.
- R9: Subpanel bit 31 enables the override and bits 25:16 give a line value. With bit 29 also set, first_line takes the value and line_count is h. With bit 29 clear, first_line is 0 and line_count takes the value. With bit 31 clear, first_line is 0 and line_count is h.
- R10: frame_start produces no fetch and no status pulse in any of these cases: mode is 1, depth code is 0, or the sequencer is not running.
- R11: When enable_i falls, off_done pulses one cycle later if mode is not 1. The next enable restarts at buffer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Controller enable level from the register block |
| frame_start | input | 1 | Frame start strobe |
| mode | input | 2 | Load mode (1: no fetch, 2: no header and no palette load) |
| depth | input | 3 | Colour depth code |
| dual | input | 1 | Alternate between two buffers |
| width_m1 | input | DIM_W | Panel width minus one |
| height_m1 | input | DIM_W | Panel height minus one |
| subpanel | input | 32 | Subpanel override register |
| top0 | input | ADDR_W | Buffer 0 start address |
| bot0 | input | ADDR_W | Buffer 0 end address |
| top1 | input | ADDR_W | Buffer 1 start address |
| bot1 | input | ADDR_W | Buffer 1 end address |
| win_lo | input | ADDR_W | Lowest valid address |
| win_hi | input | ADDR_W | Highest valid address |
| irq_mask | input | 2 | Bit 0: interrupt on buffer done, bit 1: interrupt on bounds fault |
| fetch_go | output | 1 | Fetch command pulse |
| fetch_base | output | ADDR_W | First pixel byte address |
| fetch_bytes | output | 2*DIM_W+3 | Pixel bytes in the frame |
| line_bytes | output | DIM_W+2 | Bytes per line |
| first_line | output | DIM_W | First displayed line |
| line_count | output | DIM_W+1 | Number of displayed lines |
| buf_idx | output | 1 | Buffer used by the next frame |
| buf_done | output | 2 | Buffer-done pulse, one bit per buffer |
| dma_irq | output | 1 | Interrupt pulse |
| sync_err | output | 1 | Frame-too-large pulse |
| bounds_fault | output | 1 | Address-window fault pulse |
| disable_req | output | 1 | Request to clear the enable |
| pal_done | output | 1 | Palette load request and completion pulse |
| pal_addr | output | ADDR_W | Palette source address |
| off_done | output | 1 | Frame-done pulse on disable |

## Verification
The hardest case to reach is the exact edge of the size check, where the needed bytes equal bottom minus top plus 2 or exceed it by one. The stimulus reaches it by choosing panel sizes that factor the two byte counts exactly. For a 4096-byte buffer with a 512-byte header, 163x22 lands on the limit and 17x211 lands one byte past it. The dual-buffer bounds fault is also hard to reach, because it only appears when a bad second buffer is paired with dual mode. The bench first places buffer 1 outside the window with dual set, then repeats the enable with dual clear and expects it to pass.

// File: rtl/frame_fetch_seq.sv
module frame_fetch_seq #(
  parameter int ADDR_W  = 32,
  parameter int DIM_W   = 10,
  parameter int SUB_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              frame_start,
  input  logic [1:0]        mode,
  input  logic [2:0]        depth,
  input  logic              dual,
  input  logic [DIM_W-1:0]  width_m1,
  input  logic [DIM_W-1:0]  height_m1,
  input  logic [31:0]       subpanel,
  input  logic [ADDR_W-1:0] top0,
  input  logic [ADDR_W-1:0] bot0,
  input  logic [ADDR_W-1:0] top1,
  input  logic [ADDR_W-1:0] bot1,
  input  logic [ADDR_W-1:0] win_lo,
  input  logic [ADDR_W-1:0] win_hi,
  input  logic [1:0]        irq_mask,
  output logic              fetch_go,
  output logic [ADDR_W-1:0] fetch_base,
  output logic [2*DIM_W+2:0] fetch_bytes,
  output logic [DIM_W+1:0]  line_bytes,
  output logic [DIM_W-1:0]  first_line,
  output logic [DIM_W:0]    line_count,
  output logic              buf_idx,
  output logic [1:0]        buf_done,
  output logic              dma_irq,
  output logic              sync_err,
  output logic              bounds_fault,
  output logic              disable_req,
  output logic              pal_done,
  output logic [ADDR_W-1:0] pal_addr,
  output logic              off_done
);
  localparam int BW = 2*DIM_W + 3;
  localparam int LW = DIM_W + 2;
  localparam int CW = ADDR_W + BW + 2;
  localparam int SP_ON  = 31;
  localparam int SP_SEL = 29;

  logic run, en_d, idx;

  wire rise = enable_i & ~en_d;
  wire fall = ~enable_i & en_d;

  wire [DIM_W:0]     w   = {1'b0, width_m1} + 1'b1;
  wire [DIM_W:0]     h   = {1'b0, height_m1} + 1'b1;
  wire [2*DIM_W+1:0] pix = w * h;

  logic [BW-1:0] bytes;
  logic [LW-1:0] lbytes;
  always_comb begin
    case (depth)
      3'd1:    begin bytes = BW'(pix >> 2); lbytes = LW'(w >> 2); end
      3'd2:    begin bytes = BW'(pix >> 1); lbytes = LW'(w >> 1); end
      3'd3:    begin bytes = BW'(pix);      lbytes = LW'(w);      end
      default: begin bytes = {pix, 1'b0};   lbytes = {w, 1'b0};   end
    endcase
  end

  wire [9:0] hdr = (mode == 2'd2) ? 10'd0 : (depth >= 3'd3) ? 10'd512 : 10'd32;

  wire [ADDR_W-1:0] cur_top = idx ? top1 : top0;
  wire [ADDR_W-1:0] cur_bot = idx ? bot1 : bot0;

  wire signed [CW-1:0] need_s = $signed(CW'(hdr) + CW'(bytes));
  wire signed [CW-1:0] room_s = $signed(CW'(cur_bot)) - $signed(CW'(cur_top)) + CW'(2);
  wire oversize = need_s > room_s;

  function automatic logic in_win(input logic [ADDR_W-1:0] a, lo, hi);
    return (a >= lo) && (a <= hi);
  endfunction

  wire bounds_ok = in_win(top0, win_lo, win_hi) && in_win(bot0, win_lo, win_hi) &&
                   (!dual || (in_win(top1, win_lo, win_hi) && in_win(bot1, win_lo, win_hi)));

  wire take = frame_start && run && enable_i && (mode != 2'd1) && (depth != 3'd0);

  wire              sp_on   = subpanel[SP_ON];
  wire              sp_sel  = subpanel[SP_SEL];
  wire [DIM_W-1:0]  sp_line = subpanel[SUB_LSB +: DIM_W];
  wire unused_sub = ^{subpanel[30], subpanel[28:SUB_LSB+DIM_W], subpanel[SUB_LSB-1:0]};

  assign buf_idx = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; en_d <= 1'b0; idx <= 1'b0;
      fetch_go <= 1'b0; fetch_base <= '0; fetch_bytes <= '0; line_bytes <= '0;
      first_line <= '0; line_count <= '0; buf_done <= 2'b00; dma_irq <= 1'b0;
      sync_err <= 1'b0; bounds_fault <= 1'b0; disable_req <= 1'b0;
      pal_done <= 1'b0; pal_addr <= '0; off_done <= 1'b0;
    end else begin
      en_d <= enable_i;
      fetch_go <= 1'b0; buf_done <= 2'b00; dma_irq <= 1'b0; sync_err <= 1'b0;
      bounds_fault <= 1'b0; disable_req <= 1'b0; pal_done <= 1'b0; off_done <= 1'b0;
      if (rise) begin
        idx <= 1'b0;
        if (!bounds_ok) begin
          run <= 1'b0;
          bounds_fault <= 1'b1;
          disable_req <= 1'b1;
          dma_irq <= irq_mask[1];
        end else begin
          run <= 1'b1;
          if (mode != 2'd2) begin
            pal_done <= 1'b1;
            pal_addr <= top0;
          end
        end
      end else if (fall) begin
        run <= 1'b0;
        idx <= 1'b0;
        off_done <= (mode != 2'd1);
      end else if (take) begin
        if (oversize) begin
          run <= 1'b0;
          sync_err <= 1'b1;
          disable_req <= 1'b1;
        end else begin
          fetch_go <= 1'b1;
          fetch_base <= cur_top + ADDR_W'(hdr);
          fetch_bytes <= bytes;
          line_bytes <= lbytes;
          first_line <= (sp_on && sp_sel) ? sp_line : '0;
          line_count <= (sp_on && !sp_sel) ? {1'b0, sp_line} : h;
          buf_done <= idx ? 2'b10 : 2'b01;
          dma_irq <= irq_mask[0];
          if (dual) idx <= ~idx;
        end
      end
    end
  end
endmodule

// File: rtl/frame_fetch_seq_chk.sv
module frame_fetch_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable_i,
  input logic       frame_start,
  input logic [1:0] mode,
  input logic [2:0] depth,
  input logic       fetch_go,
  input logic [1:0] buf_done,
  input logic       sync_err,
  input logic       bounds_fault,
  input logic       disable_req,
  input logic       pal_done
);
  // R6
  sync_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> disable_req && !fetch_go);
  // R3
  fault_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bounds_fault |-> disable_req && !pal_done);
  // R7
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(buf_done));
  // R7
  fetch_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |-> $past(frame_start) && $countones(buf_done) == 1);
  // R10
  no_fetch_mode1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |-> $past(mode) != 2'd1 && $past(depth) != 3'd0);
  // R2
  pal_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pal_done |-> $past(enable_i) && $past(mode) != 2'd2);
endmodule

bind frame_fetch_seq frame_fetch_seq_chk u_chk (.*);

// File: tb/frame_fetch_seq_test.sv
module frame_fetch_seq_test;
  localparam int ADDR_W = 32;
  localparam int DIM_W  = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable_i = 1'b0, frame_start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [2:0] depth = 3'd3;
  logic dual = 1'b0;
  logic [DIM_W-1:0] width_m1 = 10'd15, height_m1 = 10'd7;
  logic [31:0] subpanel = 32'd0;
  logic [ADDR_W-1:0] top0 = 32'h1000, bot0 = 32'h2000, top1 = 32'h3000, bot1 = 32'h4000;
  logic [ADDR_W-1:0] win_lo = 32'h0, win_hi = 32'hFFFF;
  logic [1:0] irq_mask = 2'b01;

  logic fetch_go, buf_idx, dma_irq, sync_err, bounds_fault, disable_req, pal_done, off_done;
  logic [ADDR_W-1:0] fetch_base, pal_addr;
  logic [2*DIM_W+2:0] fetch_bytes;
  logic [DIM_W+1:0] line_bytes;
  logic [DIM_W-1:0] first_line;
  logic [DIM_W:0] line_count;
  logic [1:0] buf_done;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  frame_fetch_seq uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_en(input logic v);
    enable_i = v;
    @(negedge clk);
  endtask

  task automatic frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic restart();
    set_en(1'b0);
    @(negedge clk);
    set_en(1'b1);
  endtask

  task automatic t_reset();
    chk("R1 pulses", {fetch_go, buf_done, dma_irq, sync_err, bounds_fault, disable_req, pal_done, off_done}, 0);
    chk("R1 buf_idx", buf_idx, 0);
  endtask

  task automatic t_enable_pal();
    mode = 2'd0; dual = 1'b0;
    set_en(1'b1);
    chk("R2 pal_done", pal_done, 1);
    chk("R2 pal_addr", pal_addr, 32'h1000);
    @(negedge clk);
    chk("R2 single pulse", pal_done, 0);
  endtask

  task automatic t_depths();
    depth = 3'd3; width_m1 = 15; height_m1 = 7;
    frame();
    chk("R7 fetch_go", fetch_go, 1);
    chk("R4 base d3", fetch_base, 32'h1200);
    chk("R5 bytes d3", fetch_bytes, 128);
    chk("R5 line d3", line_bytes, 16);
    chk("R7 buf_done", buf_done, 2'b01);
    chk("R7 irq", dma_irq, 1);
    chk("R8 idx single", buf_idx, 0);
    depth = 3'd1; irq_mask = 2'b00;
    frame();
    chk("R4 base d1", fetch_base, 32'h1020);
    chk("R5 bytes d1", fetch_bytes, 32);
    chk("R5 line d1", line_bytes, 4);
    chk("R7 no irq masked", dma_irq, 0);
    depth = 3'd2;
    frame();
    chk("R5 bytes d2", fetch_bytes, 64);
    chk("R5 line d2", line_bytes, 8);
    depth = 3'd6;
    frame();
    chk("R4 base d6", fetch_base, 32'h1200);
    chk("R5 bytes d6", fetch_bytes, 256);
    chk("R5 line d6", line_bytes, 32);
    irq_mask = 2'b01;
  endtask

  task automatic t_mode2();
    mode = 2'd2; depth = 3'd3;
    restart();
    chk("R2 no pal mode2", pal_done, 0);
    frame();
    chk("R4 base mode2", fetch_base, 32'h1000);
    chk("R5 bytes mode2", fetch_bytes, 128);
    mode = 2'd0;
  endtask

  task automatic t_dual();
    dual = 1'b1; depth = 3'd3;
    restart();
    frame();
    chk("R8 first buffer base", fetch_base, 32'h1200);
    chk("R8 done0", buf_done, 2'b01);
    chk("R8 idx toggled", buf_idx, 1);
    frame();
    chk("R8 second buffer base", fetch_base, 32'h3200);
    chk("R8 done1", buf_done, 2'b10);
    chk("R8 idx back", buf_idx, 0);
    frame();
    chk("R11 mid idx", buf_idx, 1);
    set_en(1'b0);
    chk("R11 off_done", off_done, 1);
    set_en(1'b1);
    frame();
    chk("R11 restart buffer0", fetch_base, 32'h1200);
    dual = 1'b0;
  endtask

  task automatic t_sync();
    depth = 3'd3; mode = 2'd0;
    width_m1 = 162; height_m1 = 21;
    restart();
    frame();
    chk("R6 exact fit accepted", fetch_go, 1);
    chk("R6 exact no err", sync_err, 0);
    width_m1 = 16; height_m1 = 210;
    frame();
    chk("R6 sync_err", sync_err, 1);
    chk("R6 disable_req", disable_req, 1);
    chk("R6 no fetch", fetch_go, 0);
    width_m1 = 15; height_m1 = 7;
    frame();
    chk("R6 ignored after err", {fetch_go, buf_done}, 0);
    restart();
    frame();
    chk("R6 recovers", fetch_go, 1);
  endtask

  task automatic t_bounds();
    dual = 1'b1; top1 = 32'h20000; irq_mask = 2'b10;
    restart();
    chk("R3 fault", bounds_fault, 1);
    chk("R3 disable_req", disable_req, 1);
    chk("R3 irq", dma_irq, 1);
    chk("R3 no pal", pal_done, 0);
    frame();
    chk("R3 frames ignored", fetch_go, 0);
    dual = 1'b0;
    restart();
    chk("R3 unused pair ignored", bounds_fault, 0);
    chk("R3 pal ok", pal_done, 1);
    top1 = 32'h3000; irq_mask = 2'b01;
  endtask

  task automatic t_subpanel();
    width_m1 = 15; height_m1 = 7; depth = 3'd3;
    subpanel = 32'hA005_0000;
    frame();
    chk("R9 first_line", first_line, 5);
    chk("R9 count h", line_count, 8);
    subpanel = 32'h8003_0000;
    frame();
    chk("R9 first 0", first_line, 0);
    chk("R9 count override", line_count, 3);
    subpanel = 32'h2007_0000;
    frame();
    chk("R9 off first", first_line, 0);
    chk("R9 off count", line_count, 8);
    subpanel = 32'd0;
  endtask

  task automatic t_ignored();
    depth = 3'd0;
    frame();
    chk("R10 depth0", {fetch_go, buf_done, sync_err}, 0);
    depth = 3'd3; mode = 2'd1;
    frame();
    chk("R10 mode1", {fetch_go, buf_done, sync_err}, 0);
    set_en(1'b0);
    chk("R11 no off_done mode1", off_done, 0);
    frame();
    chk("R10 not running", fetch_go, 0);
    mode = 2'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_pal();
    t_depths();
    t_mode2();
    t_dual();
    t_sync();
    t_bounds();
    t_subpanel();
    t_ignored();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule